// File: doc/BRIEF.md
# SPI Master with Command-Byte Control

This block is a full-duplex SPI master run through four small registers: a command byte, a rate byte, a data word and a status word. Software loads the rate and the outgoing word, then writes a nonzero command. The command byte is both the start trigger and the completion flag. It stays nonzero while the transfer runs, and the block clears it once slave select has been released. Software polls it for zero before it issues the next command.

A command carries a length field and a set of flag bits. A valid command pre-aligns a short word to the top of the data buffer. The block then shifts it out MSB-first on MOSI, and in the same bit slots it shifts MISO into the low end of the buffer. The received word is left right-aligned in the buffer. A command whose mode flags are wrong starts no transfer. It sets a sticky error bit, and software clears that bit by writing the status register.

Top module: `spi_cmd_master`

## Requirements
- R1: Synchronous reset sets ss_n high and sclk, mosi and busy low. Afterwards the command, rate, data and status registers all read zero.
- R2: A nonzero command is accepted only when bit 5 and bit 4 are both 1. For any other nonzero command, status bit 4 is set, ss_n never goes low, and the command register reads zero within three cycles.
- R3: Command bits [3:0] give the word length: values 1 to 15 mean that many bits and 0 means 16. A transfer makes exactly two sclk toggles per bit.
- R4: MOSI carries the low `length` bits of the data register, most significant bit first. Each bit is stable at the first sclk toggle of its bit slot.
- R5: MISO is sampled once per bit, between the two toggles of that bit. After the transfer the data register reads the received bits right-aligned in the low `length` bits, with zeros above them.
- R6: When ss_n falls, sclk takes its idle level, which is command bit 6 (1 = high, 0 = low). While ss_n is high, sclk does not change.
- R7: Every sclk toggle comes N+2 clock cycles after the previous one, where N is the rate register value and 0 stands for 256. The first toggle comes N+2 cycles after ss_n falls.
- R8: ss_n returns high one cycle after the last sclk toggle. The command register (and busy) clears one cycle after that. Busy is high exactly while the command register is nonzero.
- R9: While busy, writes to the command, rate and data registers are ignored.
- R10: The error bit stays set across later transfers until the status register is written.
- R11: Command bit 7 (transmit versus receive) does not change the transfer: both settings shift out and shift in together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 command, 1 rate, 2 data, 3 status |
| wdata | input | 16 | Write data; the command and rate use the low 8 bits |
| rdata | output | 16 | Registered read data for `addr` |
| busy | output | 1 | High while the command register is nonzero |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench builds the block with its defaults: a 16-bit data word and an 8-bit rate register. This makes every legal word length from 1 to 16 reachable, along with the full rate range, including the zero-means-256 case, all within a short run. A slave model on the serial pins measures each toggle interval against the rate and collects the MOSI bits. It also feeds a chosen MISO word, so the bench can check alignment, ordering and timing for short, full and single-bit words at both clock polarities.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_RATE = 2'd1,
    REG_DATA = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DRIVE,
    ST_EDGE,
    ST_FIN,
    ST_DONE
  } xfer_state_e;

  localparam int FLAG_POL  = 6;
  localparam int FLAG_MST  = 5;
  localparam int FLAG_FAST = 4;
  localparam int ERR_POS   = 4;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic [CMD_W-1:0] cmd,
  output logic             valid,
  output logic             pol,
  output logic [LEN_W:0]   len,
  output logic [LEN_W:0]   pre_amt
);
  import spi_cmd_pkg::*;

  logic [LEN_W-1:0] len_field;

  always_comb begin
    len_field = cmd[LEN_W-1:0];
    valid     = (cmd != '0) && cmd[FLAG_MST] && cmd[FLAG_FAST];
    pol       = cmd[FLAG_POL];
    len       = (len_field == '0) ? (LEN_W+1)'(DATA_W) : {1'b0, len_field};
    pre_amt   = (LEN_W+1)'(DATA_W) - len;
  end
endmodule

// File: rtl/spi_rate_timer.sv
module spi_rate_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RATE_W-1:0] rate,
  output logic              expire
);
  logic [RATE_W:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (rate == '0) ? ((RATE_W+1)'(1) << RATE_W) : {1'b0, rate};
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == (RATE_W+1)'(1));

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ((RATE_W+1)'(1) << RATE_W)); // R7
endmodule

// File: rtl/spi_shift_buf.sv
module spi_shift_buf #(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pre_en,
  input  logic [LEN_W:0]    pre_amt,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      q <= wdata;
    end else if (pre_en) begin
      q <= q << pre_amt;
    end else if (shift_en) begin
      q <= {q[DATA_W-2:0], 1'b0};
    end else if (sample_en) begin
      q[0] <= miso;
    end
  end

  AST_SAMPLE_LANDS: assert property (@(posedge clk) disable iff (rst)
    sample_en && !wr && !pre_en && !shift_en |=> q[0] == $past(miso)); // R5
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  parameter int RATE_W = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  import spi_cmd_pkg::*;

  xfer_state_e       state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [RATE_W-1:0] rate_q;
  logic              err_q;
  logic              phase_q;
  logic [LEN_W:0]    bits_q;
  logic [DATA_W-1:0] buf_q;

  logic           dec_valid, dec_pol;
  logic [LEN_W:0] dec_len, dec_pre;
  logic           start, bad_cmd, tmr_load, tmr_exp;
  logic           buf_wr, stat_wr, shift_en, sample_en;

  spi_cmd_decode #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_dec (
    .cmd(cmd_q), .valid(dec_valid), .pol(dec_pol),
    .len(dec_len), .pre_amt(dec_pre)
  );

  assign busy      = (cmd_q != '0);
  assign start     = (state_q == ST_IDLE) && busy && dec_valid;
  assign bad_cmd   = (state_q == ST_IDLE) && busy && !dec_valid;
  assign tmr_load  = start || ((state_q == ST_EDGE) && !(phase_q && bits_q == '0));
  assign buf_wr    = wr_en && (addr == REG_DATA) && !busy;
  assign stat_wr   = wr_en && (addr == REG_STAT);
  assign shift_en  = (state_q == ST_DRIVE) && !phase_q;
  assign sample_en = (state_q == ST_DRIVE) && phase_q;

  spi_rate_timer #(.RATE_W(RATE_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .rate(rate_q), .expire(tmr_exp)
  );

  spi_shift_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .wr(buf_wr), .wdata(wdata),
    .pre_en(start), .pre_amt(dec_pre), .shift_en(shift_en),
    .sample_en(sample_en), .miso(miso), .q(buf_q)
  );

  // register writes and status
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && addr == REG_RATE && !busy) rate_q <= wdata[RATE_W-1:0];
      if (bad_cmd)      err_q <= 1'b1;
      else if (stat_wr) err_q <= 1'b0;
    end
  end

  // transfer sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      phase_q <= 1'b0;
      bits_q  <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      ss_n    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!busy) begin
            if (wr_en && addr == REG_CMD) cmd_q <= wdata[CMD_W-1:0];
          end else if (dec_valid) begin
            ss_n    <= 1'b0;
            sclk    <= dec_pol;
            bits_q  <= dec_len;
            phase_q <= 1'b0;
            state_q <= ST_WAIT;
          end else begin
            cmd_q <= '0;
          end
        end
        ST_WAIT:  if (tmr_exp) state_q <= ST_DRIVE;
        ST_DRIVE: begin
          if (!phase_q) mosi <= buf_q[DATA_W-1];
          else          bits_q <= bits_q - 1'b1;
          state_q <= ST_EDGE;
        end
        ST_EDGE: begin
          sclk    <= ~sclk;
          phase_q <= ~phase_q;
          state_q <= (phase_q && bits_q == '0) ? ST_FIN : ST_WAIT;
        end
        ST_FIN: begin
          ss_n    <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          cmd_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        REG_CMD:  rdata <= DATA_W'(cmd_q);
        REG_RATE: rdata <= DATA_W'(rate_q);
        REG_DATA: rdata <= buf_q;
        default:  rdata <= DATA_W'({err_q, {ERR_POS{1'b0}}});
      endcase
    end
  end

  AST_INVALID_NO_SS: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |=> ss_n && cmd_q == '0); // R2
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
    ss_n && $past(ss_n) |-> $stable(sclk)); // R6
  AST_CMD_AFTER_SS: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_n) |=> cmd_q == '0); // R8
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(rate_q)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_q) && !$past(stat_wr) |-> err_q); // R10
endmodule

// File: tb/test_spi_cmd_master.sv
module test_spi_cmd_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, sclk, mosi, ss_n;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_cmd_master i_spi_cmd_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n)
  );

  // vectors: cmd[47:40] rate[39:32] data[31:16] miso word[15:0]
  localparam logic [47:0] VEC [0:6] = '{
    {8'hF0, 8'd3, 16'h0D35, 16'hA5C3},
    {8'hBC, 8'd1, 16'h0ABC, 16'h0123},
    {8'h31, 8'd2, 16'h0001, 16'h0001},
    {8'h7F, 8'd1, 16'h7FFF, 16'h4000},
    {8'h38, 8'd5, 16'h00A5, 16'h005A},
    {8'hB0, 8'd0, 16'h8001, 16'hFFFF},
    {8'hB8, 8'd5, 16'h00A5, 16'h005A}
  };

  // slave model and timing monitor
  int          cyc = 0, ss_fall = 0, ss_rise = 0, busy_fall = 0;
  int          first_tog = 0, last_tog = 0, tog = 0, bad_gap = 0, exp_half = 0;
  int          cur_len = 1;
  logic [15:0] rx_cur = '0, slave_rx = '0;
  logic        idle_lvl = 1'b0, ss_seen = 1'b0;
  logic        p_ss = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!ss_n && p_ss) begin
      ss_fall = cyc; idle_lvl = sclk; tog = 0; slave_rx = '0; ss_seen = 1'b1;
      miso = rx_cur[cur_len-1];
    end else if (!ss_n && sclk != p_sclk) begin
      tog = tog + 1;
      if (tog == 1) first_tog = cyc;
      else if (cyc - last_tog != exp_half) bad_gap = bad_gap + 1;
      last_tog = cyc;
      if (tog % 2 == 1) slave_rx = {slave_rx[14:0], mosi};
      else if (tog / 2 < cur_len) miso = rx_cur[cur_len-1-tog/2];
    end
    if (ss_n && !p_ss) ss_rise = cyc;
    if (!busy && p_busy) busy_fall = cyc;
    p_ss = ss_n; p_sclk = sclk; p_busy = busy;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [15:0] lmask(input int len);
    return (len == 16) ? 16'hFFFF : ((16'd1 << len) - 16'd1);
  endfunction

  task automatic run_check(input logic [47:0] v, output logic [15:0] res);
    logic [7:0]  c = v[47:40];
    logic [7:0]  r = v[39:32];
    logic [15:0] m;
    cur_len  = (c[3:0] == 0) ? 16 : int'(c[3:0]);
    rx_cur   = v[15:0];
    exp_half = ((r == 0) ? 256 : int'(r)) + 2;
    m = lmask(cur_len);
    wr_reg(2'd1, {8'd0, r});
    wr_reg(2'd2, v[31:16]);
    bad_gap = 0;
    wr_reg(2'd0, {8'd0, c});
    wait_idle();
    rd_reg(2'd2, res);
    chk(tog == 2 * cur_len, "R3 toggle count", tog, 2 * cur_len);
    chk(idle_lvl == c[6], "R6 idle level", idle_lvl, c[6]);
    chk(first_tog - ss_fall == exp_half, "R7 first toggle delay", first_tog - ss_fall, exp_half);
    chk(bad_gap == 0, "R7 half period", bad_gap, 0);
    chk((slave_rx & m) == (v[31:16] & m), "R4 mosi word", slave_rx & m, v[31:16] & m);
    chk(res == (v[15:0] & m), "R5 received word", res, v[15:0] & m);
    chk(ss_rise - last_tog == 1, "R8 ss release", ss_rise - last_tog, 1);
    chk(busy_fall - ss_rise == 1, "R8 command clear", busy_fall - ss_rise, 1);
  endtask

  initial begin
    logic [15:0] d, res, res4;
    res4 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ss_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && busy == 1'b0,
        "R1 pins after reset", {ss_n, sclk, mosi, busy}, 4'b1000);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk(d == 16'h0, "R1 register after reset", d, 0);
    end

    // main vector walk
    for (int i = 0; i < 7; i++) begin
      run_check(VEC[i], res);
      if (i == 4) res4 = res;
      if (i == 6) chk(res == res4, "R11 transmit flag no effect", res, res4);
    end

    // R2 unsupported commands, R10 sticky error
    foreach (VEC[k]) if (k < 3) begin
      logic [7:0] badc = (k == 0) ? 8'h48 : (k == 1) ? 8'h20 : 8'h90;
      wr_reg(2'd3, 16'h0);
      ss_seen = 1'b0;
      wr_reg(2'd0, {8'd0, badc});
      repeat (3) @(negedge clk);
      chk(!busy && !ss_seen, "R2 no transfer on bad command", {busy, ss_seen}, 0);
      rd_reg(2'd0, d);
      chk(d == 16'h0, "R2 command cleared", d, 0);
      rd_reg(2'd3, d);
      chk(d[4] == 1'b1, "R2 error flag", d, 16'h10);
    end
    run_check(VEC[2], res);
    rd_reg(2'd3, d);
    chk(d[4] == 1'b1, "R10 error survives transfer", d, 16'h10);
    wr_reg(2'd3, 16'h0);
    rd_reg(2'd3, d);
    chk(d == 16'h0, "R10 error cleared by status write", d, 0);

    // R9 writes while busy
    cur_len = 8; rx_cur = 16'h003C; exp_half = 4;
    wr_reg(2'd1, 16'd2);
    wr_reg(2'd2, 16'h00F0);
    bad_gap = 0;
    wr_reg(2'd0, 16'h00F8);
    wr_reg(2'd2, 16'hFFFF);
    wr_reg(2'd1, 16'd1);
    wr_reg(2'd0, 16'h0031);
    wait_idle();
    rd_reg(2'd2, d);
    chk(d == 16'h003C, "R9 data write ignored", d, 16'h3C);
    chk(slave_rx[7:0] == 8'hF0, "R9 sent word intact", slave_rx[7:0], 8'hF0);
    chk(bad_gap == 0 && first_tog - ss_fall == 4, "R9 rate kept", first_tog - ss_fall, 4);
    rd_reg(2'd1, d);
    chk(d == 16'd2, "R9 rate register", d, 2);
    repeat (5) @(negedge clk);
    chk(!busy, "R9 command write ignored", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule